// File: doc/BRIEF.md
# Unaligned Load/Store Splitter

This block sits between the load/store stage of a 32-bit processor and a data bus that only understands whole, aligned words. The requester may ask for a byte, a halfword or a word at any byte address. The block turns each request into one or two aligned bus beats. Each beat carries byte enables and write data moved into the correct byte lanes. For a load, the block gathers the returned bytes, moves them down to bit 0 and extends them to 32 bits.

An access that stays inside one word, aligned or not, takes a single beat marked as the first half. An access that runs past the end of its word takes two beats. The first beat carries the bytes from the start address up to the top of that word. The second beat, marked as the second half, carries the remaining bytes from lane 0 of the next word. Error responses from the bus are collected over both beats. When the access ends, a one-cycle done pulse presents the result, the error, and whether the address was misaligned.

Top module: `dacc_splitter`

## Requirements
- R1: Every bus address has its two low bits at zero. The first beat goes to the word that contains the start address, and a second beat goes to the following word (first address + 4).
- R2: Byte enable bit k and data bits [8k+7:8k] belong to the byte at word offset k. The bytes of a store are placed starting at lane (address mod 4): a byte store of 0xFF to 0x12 drives address 0x10, byte enables 0b0100 and data 0x00FF0000.
- R3: An access whose last byte lies in the next word takes exactly two beats. The first beat has first_half=1 and enables the lanes from the start offset up to lane 3. The second beat has second_half=1 and enables the remaining bytes from lane 0 upward. The second beat is requested only after the first beat's response.
- R4: An access that fits in one word takes exactly one beat with first_half=1 and second_half=0, even when it is misaligned (e.g. a halfword at 0x1 is a single beat to 0x0 with enables 0b0110).
- R5: The size encoding is 0 = byte, 1 = halfword, 2 = word. The byte at the start address becomes bits [7:0] of the load result, and following bytes go to higher bits. When unsigned=0, bits above the access width copy the top bit of the accessed data. When unsigned=1, those bits are zero.
- R6: A beat that completes with bus_err_i=1 makes err_o=1 at done. An error on the first beat still lets the second beat be issued. With no error on any beat, err_o=0.
- R7: req_ready_o is 1 only when no access is in progress. A new request is taken only when req_valid_i=1 and req_ready_o=1. bus_req_o stays high with a stable address and enables until bus_gnt_i. The response for a beat (bus_rvalid_i) comes in a later cycle than its grant.
- R8: done_o is a single-cycle pulse after the final beat's response. While done_o=1, misaligned_o is 1 exactly when the address is not a multiple of the access size.
- R9: bus_we_o is 1 on the beats of a store and 0 on the beats of a load. rdata_o at done is 0 for a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Access request |
| req_ready_o | output | 1 | Block can take a request |
| req_write_i | input | 1 | 1 = store, 0 = load |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word |
| req_unsigned_i | input | 1 | Zero-extend load result |
| req_addr_i | input | 32 | Byte address |
| req_wdata_i | input | 32 | Store data, right-justified |
| bus_req_o | output | 1 | Beat request |
| bus_gnt_i | input | 1 | Beat accepted by bus |
| bus_addr_o | output | 32 | Word-aligned beat address |
| bus_we_o | output | 1 | Beat is a write |
| bus_be_o | output | 4 | Byte enables of the beat |
| bus_wdata_o | output | 32 | Lane-steered write data |
| bus_first_o | output | 1 | Beat is the first half |
| bus_second_o | output | 1 | Beat is the second half |
| bus_rvalid_i | input | 1 | Beat response |
| bus_rdata_i | input | 32 | Beat read data |
| bus_err_i | input | 1 | Beat error response |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 32 | Merged, extended load result |
| err_o | output | 1 | Any beat returned an error |
| misaligned_o | output | 1 | Address not size-aligned |

## Verification
The tests cover aligned words, misaligned halfwords and bytes that stay inside one word, and halfwords and words that cross a word boundary at offsets 1, 2 and 3. Together these separate the one-beat path from the two-beat path and show whether the lane shift uses the offset correctly. Bytes are stored and then read back with their top bit set, once signed and once unsigned, to show whether the extension follows the flag. Errors are injected on the first beat only, the second beat only, or neither, with and without a delayed grant. This shows that the error is collected across both beats and that the second beat is never dropped.

// File: rtl/dacc_pkg.sv
package dacc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } dacc_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;
    localparam logic [1:0] SZ_WORD = 2'd2;
endpackage

// File: rtl/dacc_lane_map.sv
module dacc_lane_map #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic [OW-1:0] off_i,
    input  logic [1:0]    size_i,
    input  logic [DW-1:0] wdata_i,
    output logic [NB-1:0] be_lo_o,
    output logic [NB-1:0] be_hi_o,
    output logic [DW-1:0] wd_lo_o,
    output logic [DW-1:0] wd_hi_o,
    output logic          split_o,
    output logic          misal_o
);
    logic [1:0]      sz;
    logic [OW:0]     nbytes;
    logic [OW:0]     nb_m1;
    logic [2*NB-1:0] base;
    logic [2*NB-1:0] mask;
    logic [2*DW-1:0] wsh;

    always_comb begin
        sz      = (size_i > 2'(OW)) ? 2'(OW) : size_i;
        nbytes  = (OW+1)'(1) << sz;
        nb_m1   = nbytes - (OW+1)'(1);
        base    = ((2*NB)'(1) << nbytes) - (2*NB)'(1);
        mask    = base << off_i;
        wsh     = {{DW{1'b0}}, wdata_i} << {off_i, 3'b000};
        be_lo_o = mask[NB-1:0];
        be_hi_o = mask[2*NB-1:NB];
        wd_lo_o = wsh[DW-1:0];
        wd_hi_o = wsh[2*DW-1:DW];
        split_o = |mask[2*NB-1:NB];
        misal_o = (off_i & nb_m1[OW-1:0]) != '0;
    end
endmodule

// File: rtl/dacc_load_merge.sv
module dacc_load_merge #(
    parameter int DW = 32,
    localparam int NB = DW / 8,
    localparam int OW = $clog2(NB)
) (
    input  logic [DW-1:0] lo_i,
    input  logic [DW-1:0] hi_i,
    input  logic [OW-1:0] off_i,
    input  logic [1:0]    size_i,
    input  logic          unsigned_i,
    output logic [DW-1:0] res_o
);
    import dacc_pkg::*;

    logic [2*DW-1:0] joined;
    logic            sx;

    always_comb begin
        joined = {hi_i, lo_i} >> {off_i, 3'b000};
        sx     = 1'b0;
        case (size_i)
            SZ_BYTE: begin
                sx    = ~unsigned_i & joined[7];
                res_o = {{(DW-8){sx}}, joined[7:0]};
            end
            SZ_HALF: begin
                sx    = ~unsigned_i & joined[15];
                res_o = {{(DW-16){sx}}, joined[15:0]};
            end
            default: res_o = joined[DW-1:0];
        endcase
    end
endmodule

// File: rtl/dacc_splitter.sv
module dacc_splitter #(
    parameter int ADDR_W = 32,
    parameter int DW     = 32,
    localparam int NB    = DW / 8,
    localparam int OW    = $clog2(NB)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    output logic              req_ready_o,
    input  logic              req_write_i,
    input  logic [1:0]        req_size_i,
    input  logic              req_unsigned_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DW-1:0]     req_wdata_i,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic              bus_we_o,
    output logic [NB-1:0]     bus_be_o,
    output logic [DW-1:0]     bus_wdata_o,
    output logic              bus_first_o,
    output logic              bus_second_o,
    input  logic              bus_rvalid_i,
    input  logic [DW-1:0]     bus_rdata_i,
    input  logic              bus_err_i,
    output logic              done_o,
    output logic [DW-1:0]     rdata_o,
    output logic              err_o,
    output logic              misaligned_o
);
    import dacc_pkg::*;

    localparam int WIDX_W = ADDR_W - OW;

    typedef struct packed {
        dacc_state_e       st;
        logic              beat;
        logic              wr;
        logic [1:0]        size;
        logic              uns;
        logic [WIDX_W-1:0] widx;
        logic [OW-1:0]     off;
        logic [DW-1:0]     wdata;
        logic [DW-1:0]     rd_lo;
        logic [DW-1:0]     rd_hi;
        logic              err;
    } ctx_t;

    ctx_t ctx_d, ctx_q;

    logic [NB-1:0] be_lo, be_hi;
    logic [DW-1:0] wd_lo, wd_hi, merged;
    logic          split, misal;

    dacc_lane_map #(.DW(DW)) u_lane (
        .off_i   (ctx_q.off),
        .size_i  (ctx_q.size),
        .wdata_i (ctx_q.wdata),
        .be_lo_o (be_lo),
        .be_hi_o (be_hi),
        .wd_lo_o (wd_lo),
        .wd_hi_o (wd_hi),
        .split_o (split),
        .misal_o (misal)
    );

    dacc_load_merge #(.DW(DW)) u_merge (
        .lo_i       (ctx_q.rd_lo),
        .hi_i       (ctx_q.rd_hi),
        .off_i      (ctx_q.off),
        .size_i     (ctx_q.size),
        .unsigned_i (ctx_q.uns),
        .res_o      (merged)
    );

    always_comb begin
        ctx_d = ctx_q;
        case (ctx_q.st)
            ST_IDLE: begin
                if (req_valid_i) begin
                    ctx_d.st    = ST_ISSUE;
                    ctx_d.beat  = 1'b0;
                    ctx_d.wr    = req_write_i;
                    ctx_d.size  = req_size_i;
                    ctx_d.uns   = req_unsigned_i;
                    ctx_d.widx  = req_addr_i[ADDR_W-1:OW];
                    ctx_d.off   = req_addr_i[OW-1:0];
                    ctx_d.wdata = req_wdata_i;
                    ctx_d.rd_lo = '0;
                    ctx_d.rd_hi = '0;
                    ctx_d.err   = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (bus_gnt_i) ctx_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (bus_rvalid_i) begin
                    if (ctx_q.beat) ctx_d.rd_hi = bus_rdata_i;
                    else            ctx_d.rd_lo = bus_rdata_i;
                    ctx_d.err = ctx_q.err | bus_err_i;
                    if (!ctx_q.beat && split) begin
                        ctx_d.beat = 1'b1;
                        ctx_d.st   = ST_ISSUE;
                    end else begin
                        ctx_d.st = ST_DONE;
                    end
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign req_ready_o  = (ctx_q.st == ST_IDLE);
    assign bus_req_o    = (ctx_q.st == ST_ISSUE);
    assign bus_addr_o   = {ctx_q.widx + WIDX_W'(ctx_q.beat), {OW{1'b0}}};
    assign bus_we_o     = ctx_q.wr;
    assign bus_be_o     = ctx_q.beat ? be_hi : be_lo;
    assign bus_wdata_o  = ctx_q.beat ? wd_hi : wd_lo;
    assign bus_first_o  = bus_req_o & ~ctx_q.beat;
    assign bus_second_o = bus_req_o & ctx_q.beat;
    assign done_o       = (ctx_q.st == ST_DONE);
    assign rdata_o      = (done_o && !ctx_q.wr) ? merged : '0;
    assign err_o        = done_o & ctx_q.err;
    assign misaligned_o = (ctx_q.st != ST_IDLE) & misal;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_gnt_i |=> bus_req_o && $stable(bus_addr_o) && $stable(bus_be_o)); // R7
    AST_BE_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> bus_be_o != '0); // R2
    AST_ONE_HALF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> $countones({bus_first_o, bus_second_o}) == 1); // R4
    AST_SECOND_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_second_o) |-> $past(bus_rvalid_i)); // R3
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R8
    AST_DONE_AFTER_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(bus_rvalid_i)); // R6
endmodule

// File: tb/sim_dacc_splitter.sv
module sim_dacc_splitter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid_i = 1'b0, req_write_i = 1'b0, req_unsigned_i = 1'b0;
    logic [1:0]  req_size_i = '0;
    logic [31:0] req_addr_i = '0, req_wdata_i = '0;
    logic        req_ready_o, bus_req_o, bus_we_o, bus_first_o, bus_second_o;
    logic        bus_gnt_i = 1'b0, bus_rvalid_i = 1'b0, bus_err_i = 1'b0;
    logic [31:0] bus_addr_o, bus_wdata_o, rdata_o;
    logic [31:0] bus_rdata_i = '0;
    logic [3:0]  bus_be_o;
    logic        done_o, err_o, misaligned_o;

    always #2 clk = ~clk;

    dacc_splitter u0 (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    logic [31:0] mem [0:15];

    logic [31:0] rec_addr [0:3];
    logic [3:0]  rec_be   [0:3];
    logic [31:0] rec_wd   [0:3];
    logic        rec_first[0:3], rec_second[0:3], rec_we[0:3];
    int          nbeats;
    logic [31:0] got_rdata;
    logic        got_err, got_mis, got_done2;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(input logic [31:0] a);
        logic [31:0] w;
        w = mem[a[5:2]];
        return w[a[1:0]*8 +: 8];
    endfunction

    // runs one access, services the bus, checks every generic property
    task automatic run_access(input bit wr, input logic [1:0] sz, input logic [31:0] a,
                              input logic [31:0] wd, input bit uns, input logic [1:0] errm,
                              input int gdel);
        int nbyt;
        int exp_nb;
        logic [3:0]  ebe [0:1];
        logic [31:0] ewd [0:1];
        logic [31:0] eres;
        bit fin;
        nbyt = 1 << sz;
        ebe[0] = '0; ebe[1] = '0; ewd[0] = '0; ewd[1] = '0; eres = '0;
        exp_nb = 1;
        for (int i = 0; i < nbyt; i++) begin
            logic [31:0] ab;
            int bt;
            ab = a + 32'(i);
            bt = (ab[31:2] != a[31:2]) ? 1 : 0;
            if (bt == 1) exp_nb = 2;
            ebe[bt][ab[1:0]] = 1'b1;
            ewd[bt][ab[1:0]*8 +: 8] = wd[i*8 +: 8];
            eres[i*8 +: 8] = mem_byte(ab);
        end
        if (!uns && nbyt < 4 && eres[nbyt*8-1]) begin
            for (int b = nbyt*8; b < 32; b++) eres[b] = 1'b1;
        end
        if (wr) eres = '0;

        @(negedge clk);
        chk(req_ready_o === 1'b1, "R7 ready when idle", 32'(req_ready_o), 32'd1);
        req_valid_i = 1'b1; req_write_i = wr; req_size_i = sz; req_addr_i = a;
        req_wdata_i = wd; req_unsigned_i = uns;
        @(posedge clk);
        @(negedge clk);
        req_valid_i = 1'b0;
        nbeats = 0; fin = 0; got_err = 0; got_mis = 0; got_rdata = '0;
        for (int cyc = 0; cyc < 60 && !fin; cyc++) begin
            if (done_o) begin
                got_rdata = rdata_o; got_err = err_o; got_mis = misaligned_o;
                fin = 1;
            end else if (bus_req_o) begin
                if (nbeats < 4) begin
                    rec_addr[nbeats] = bus_addr_o; rec_be[nbeats] = bus_be_o;
                    rec_wd[nbeats] = bus_wdata_o; rec_first[nbeats] = bus_first_o;
                    rec_second[nbeats] = bus_second_o; rec_we[nbeats] = bus_we_o;
                end
                chk(req_ready_o === 1'b0, "R7 busy not ready", 32'(req_ready_o), 32'd0);
                for (int g = 0; g < gdel; g++) begin
                    @(posedge clk);
                    @(negedge clk);
                    chk(bus_req_o === 1'b1 && bus_addr_o === rec_addr[nbeats & 3],
                        "R7 request held until grant", bus_addr_o, rec_addr[nbeats & 3]);
                end
                bus_gnt_i = 1'b1;
                @(posedge clk);
                @(negedge clk);
                bus_gnt_i = 1'b0;
                bus_rvalid_i = 1'b1;
                bus_rdata_i = mem[bus_addr_o[5:2]];
                bus_err_i = errm[nbeats & 1];
                if (bus_we_o) begin
                    for (int l = 0; l < 4; l++)
                        if (bus_be_o[l]) mem[bus_addr_o[5:2]][l*8 +: 8] = bus_wdata_o[l*8 +: 8];
                end
                @(posedge clk);
                @(negedge clk);
                bus_rvalid_i = 1'b0; bus_err_i = 1'b0;
                nbeats++;
            end else begin
                @(posedge clk);
                @(negedge clk);
            end
        end
        chk(fin == 1, "R8 done reached", 32'(fin), 32'd1);
        @(posedge clk);
        @(negedge clk);
        chk(done_o === 1'b0, "R8 done single cycle", 32'(done_o), 32'd0);

        chk(nbeats == exp_nb, (exp_nb == 2) ? "R3 two beats" : "R4 one beat", 32'(nbeats), 32'(exp_nb));
        for (int b = 0; b < exp_nb && b < nbeats; b++) begin
            logic [31:0] lm;
            lm = '0;
            for (int l = 0; l < 4; l++) if (ebe[b][l]) lm[l*8 +: 8] = 8'hFF;
            chk(rec_addr[b] === ((a & 32'hFFFF_FFFC) + 32'(4*b)), "R1 beat address", rec_addr[b],
                (a & 32'hFFFF_FFFC) + 32'(4*b));
            chk(rec_be[b] === ebe[b], "R2 byte enables", 32'(rec_be[b]), 32'(ebe[b]));
            chk(rec_first[b] === (b == 0) && rec_second[b] === (b == 1), "R3 half flags",
                {30'd0, rec_second[b], rec_first[b]}, (b == 0) ? 32'd1 : 32'd2);
            chk(rec_we[b] === wr, "R9 write enable", 32'(rec_we[b]), 32'(wr));
            if (wr) chk((rec_wd[b] & lm) === ewd[b], "R2 write lanes", rec_wd[b] & lm, ewd[b]);
        end
        chk(got_rdata === eres, wr ? "R9 store result zero" : "R5 load result", got_rdata, eres);
        chk(got_err === ((errm[0]) || (exp_nb == 2 && errm[1])), "R6 error", 32'(got_err),
            32'((errm[0]) || (exp_nb == 2 && errm[1])));
        chk(got_mis === ((a % nbyt) != 0), "R8 misaligned flag", 32'(got_mis), 32'((a % nbyt) != 0));
    endtask

    task automatic t_reset;
        chk(req_ready_o === 1'b1, "R7 reset ready", 32'(req_ready_o), 32'd1);
        chk(bus_req_o === 1'b0, "R7 reset no request", 32'(bus_req_o), 32'd0);
        chk(done_o === 1'b0, "R8 reset no done", 32'(done_o), 32'd0);
    endtask

    task automatic t_byte_store_example;
        run_access(1'b1, 2'd0, 32'h12, 32'hFF, 1'b0, 2'b00, 0);
        chk(rec_addr[0] === 32'h10 && rec_be[0] === 4'b0100, "R2 example address/enables",
            {rec_addr[0][27:0], rec_be[0]}, {28'h10, 4'b0100});
        chk(rec_wd[0] === 32'h00FF0000, "R2 example data", rec_wd[0], 32'h00FF0000);
    endtask

    task automatic t_aligned_word;
        run_access(1'b1, 2'd2, 32'h20, 32'hCAFE_1234, 1'b0, 2'b00, 0);
        run_access(1'b0, 2'd2, 32'h20, 32'h0, 1'b0, 2'b00, 0);
        chk(got_rdata === 32'hCAFE_1234, "R5 aligned word readback", got_rdata, 32'hCAFE_1234);
    endtask

    task automatic t_word_cross;
        run_access(1'b0, 2'd2, 32'h3, 32'h0, 1'b0, 2'b00, 0);
        chk(rec_addr[0] === 32'h0 && rec_addr[1] === 32'h4, "R3 crossing word addresses",
            rec_addr[1], 32'h4);
        chk(rec_be[1] === 4'b0111, "R3 second beat from lane 0", 32'(rec_be[1]), 32'h7);
        run_access(1'b1, 2'd2, 32'h2D, 32'h1122_3344, 1'b0, 2'b00, 0);
        run_access(1'b0, 2'd2, 32'h2D, 32'h0, 1'b0, 2'b00, 0);
        chk(got_rdata === 32'h1122_3344, "R3 crossing word readback", got_rdata, 32'h1122_3344);
    endtask

    task automatic t_half_inside;
        run_access(1'b0, 2'd1, 32'h1, 32'h0, 1'b1, 2'b00, 0);
        chk(rec_be[0] === 4'b0110 && rec_first[0] === 1'b1, "R4 halfword inside word",
            32'(rec_be[0]), 32'h6);
        run_access(1'b0, 2'd0, 32'h37, 32'h0, 1'b1, 2'b00, 0);
    endtask

    task automatic t_sign;
        run_access(1'b1, 2'd0, 32'h21, 32'h85, 1'b0, 2'b00, 0);
        run_access(1'b0, 2'd0, 32'h21, 32'h0, 1'b0, 2'b00, 0);
        chk(got_rdata === 32'hFFFF_FF85, "R5 signed byte", got_rdata, 32'hFFFF_FF85);
        run_access(1'b0, 2'd0, 32'h21, 32'h0, 1'b1, 2'b00, 0);
        chk(got_rdata === 32'h0000_0085, "R5 unsigned byte", got_rdata, 32'h85);
        run_access(1'b1, 2'd1, 32'h33, 32'h8001, 1'b0, 2'b00, 0);
        run_access(1'b0, 2'd1, 32'h33, 32'h0, 1'b0, 2'b00, 0);
        chk(got_rdata === 32'hFFFF_8001, "R5 signed crossing half", got_rdata, 32'hFFFF_8001);
        run_access(1'b0, 2'd1, 32'h33, 32'h0, 1'b1, 2'b00, 0);
        chk(got_rdata === 32'h0000_8001, "R5 unsigned crossing half", got_rdata, 32'h8001);
    endtask

    task automatic t_errors;
        run_access(1'b0, 2'd2, 32'h6, 32'h0, 1'b0, 2'b01, 0);
        chk(nbeats == 2, "R6 second beat after first error", 32'(nbeats), 32'd2);
        run_access(1'b0, 2'd2, 32'h6, 32'h0, 1'b0, 2'b10, 1);
        chk(got_err === 1'b1, "R6 error on second beat", 32'(got_err), 32'd1);
        run_access(1'b1, 2'd1, 32'h1A, 32'h5A5A, 1'b0, 2'b01, 0);
    endtask

    task automatic t_grant_delay;
        run_access(1'b1, 2'd2, 32'h3E, 32'hA1B2_C3D4, 1'b0, 2'b00, 3);
        run_access(1'b0, 2'd2, 32'h3E, 32'h0, 1'b0, 2'b00, 2);
        chk(got_rdata === 32'hA1B2_C3D4, "R7 delayed grant readback", got_rdata, 32'hA1B2_C3D4);
    endtask

    initial begin
        for (int k = 0; k < 16; k++) mem[k] = 32'h0403_0201 * 32'(k + 1) ^ 32'h80C0_40A0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_byte_store_example();
        t_aligned_word();
        t_word_cross();
        t_half_inside();
        t_sign();
        t_errors();
        t_grant_delay();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual %h expected %h", 32'd1, 32'd0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule